// File: doc/BRIEF.md
# Per-Thread Recency Histogram Profiler

This block watches the access stream of an N-way set-associative cache that several hardware threads share. For every set it keeps a true least-recently-used ordering of the tags that live there. When an access arrives with a thread number, a set index and a tag, the block finds how deep in that set's ordering the tag sits (depth 1 is the most recently used line) or finds that the tag is absent. It then adds one to the matching bin of that thread's histogram and moves the tag to the front of the ordering.

Each thread owns WAYS+1 saturating bins: one per recency depth and one for misses. A readout port selects a thread and returns, one cycle later, both a single chosen bin and the miss count that the same access stream would have produced in a cache with only K ways. A free-running cycle counter sits beside the histogram so that the counts can be turned into per-cycle rates outside the block. A synchronous clear zeroes the bins and the cycle counter but keeps the recency orderings.

Top module: `sdp_profiler`

## Requirements
- R1: With the default of 8 ways each thread has 9 bins; bin index b in 0..7 counts hits at recency depth b+1, and bin index 8 counts misses; `rd_bin` selects a bin by this index.
- R2: A hit at recency depth d (1 = most recently used) adds one to bin d-1 of the accessing thread only.
- R3: An access whose tag is absent from the set's ordering adds one to the miss bin (index 8) of the accessing thread.
- R4: After any access its tag is at depth 1; tags that were shallower than its old depth move one deeper; on a miss in a full set the deepest tag leaves, so a later access to it is a miss.
- R5: Each set keeps its own ordering: a tag seen in one set is a miss in a different set, and accesses from all threads share the ordering of a set.
- R6: `rd_pred_miss` equals the miss bin plus bins K..7 (depths K+1..8) of the selected thread for K = `rd_k`; K=8 gives the miss bin alone and K=0 gives the total access count.
- R7: A bin that has reached 2^CNT_W-1 stays there on further increments.
- R8: A `clr` cycle sets every bin and the cycle counter to zero and leaves the recency orderings unchanged; an access in the `clr` cycle is not counted.
- R9: `cycle_count` grows by one each cycle after reset or clear and saturates at its maximum.
- R10: After reset all bins are zero and every set is empty, so the first access to any tag is a miss.
- R11: An access is reflected in the bins two cycles after it is presented; `rd_bin_count` and `rd_pred_miss` show the selection one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of bins and cycle counter |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_tid | input | TID_W | Thread number of the access |
| acc_set | input | SET_W | Set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| rd_tid | input | TID_W | Thread selected for readout |
| rd_bin | input | POS_W | Bin index selected for readout |
| rd_k | input | POS_W | Reduced associativity K for the prediction |
| rd_bin_count | output | CNT_W | Registered value of the selected bin |
| rd_pred_miss | output | CNT_W+POS_W | Registered predicted miss count at K ways |
| cycle_count | output | CYC_W | Cycles since reset or last clear |

## Verification
The stream mixes cold misses in fresh sets, re-references at several depths, back-to-back repeats of one tag, and a ninth distinct tag that pushes the oldest line out of a full set; these separate a wrong depth from a wrong shift or a wrong eviction. A second thread touching the same set shows that the ordering is shared but the bins are not, and the same tag in another set shows set isolation. Sweeping K from 0 to 8 over one histogram tells a correct suffix sum from an off-by-one range, and a long run of hits with narrow bins exercises saturation; clearing and then hitting an old tag shows that clear spares the orderings.

// File: rtl/sdp_pkg.sv
`timescale 1ns/1ps
package sdp_pkg;
  parameter int unsigned DEF_WAYS    = 8;
  parameter int unsigned DEF_SETS    = 16;
  parameter int unsigned DEF_TAG_W   = 12;
  parameter int unsigned DEF_THREADS = 2;
  parameter int unsigned DEF_CNT_W   = 32;
  parameter int unsigned DEF_CYC_W   = 40;
endpackage

// File: rtl/sdp_recency.sv
`timescale 1ns/1ps
module sdp_recency #(
  parameter int unsigned WAYS  = sdp_pkg::DEF_WAYS,
  parameter int unsigned SETS  = sdp_pkg::DEF_SETS,
  parameter int unsigned TAG_W = sdp_pkg::DEF_TAG_W,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned POS_W = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [POS_W-1:0] hit_pos
);
  // depth 0 of each set is the most recently used line
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  val_q [SETS];

  always_comb begin
    for (int j = 0; j < WAYS; j++)
      hit_vec[j] = val_q[acc_set][j] && (tag_q[acc_set][j] == acc_tag);
  end

  always_comb begin
    hit_pos = POS_W'(WAYS);
    for (int j = WAYS - 1; j >= 0; j--)
      if (hit_vec[j]) hit_pos = POS_W'(j);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else if (acc_valid) begin
      tag_q[acc_set][0] <= acc_tag;
      val_q[acc_set][0] <= 1'b1;
      for (int j = 1; j < WAYS; j++) begin
        if (POS_W'(j) <= hit_pos) begin
          tag_q[acc_set][j] <= tag_q[acc_set][j-1];
          val_q[acc_set][j] <= val_q[acc_set][j-1];
        end
      end
    end
  end
endmodule

// File: rtl/sdp_hist.sv
`timescale 1ns/1ps
module sdp_hist #(
  parameter int unsigned THREADS = sdp_pkg::DEF_THREADS,
  parameter int unsigned BINS    = sdp_pkg::DEF_WAYS + 1,
  parameter int unsigned CNT_W   = sdp_pkg::DEF_CNT_W,
  localparam int unsigned TID_W = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned BIN_W = $clog2(BINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_valid,
  input  logic [TID_W-1:0] inc_tid,
  input  logic [BIN_W-1:0] inc_bin,
  input  logic [TID_W-1:0] rd_tid,
  output logic [CNT_W-1:0] row [BINS]
);
  logic [CNT_W-1:0] cnt_q [THREADS][BINS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int t = 0; t < THREADS; t++)
        for (int b = 0; b < BINS; b++)
          cnt_q[t][b] <= '0;
    end else if (inc_valid) begin
      for (int t = 0; t < THREADS; t++)
        for (int b = 0; b < BINS; b++)
          if (TID_W'(t) == inc_tid && BIN_W'(b) == inc_bin && cnt_q[t][b] != '1)
            cnt_q[t][b] <= cnt_q[t][b] + 1'b1;
    end
  end

  always_comb begin
    for (int b = 0; b < BINS; b++) begin
      row[b] = '0;
      for (int t = 0; t < THREADS; t++)
        if (TID_W'(t) == rd_tid) row[b] = cnt_q[t][b];
    end
  end
endmodule

// File: rtl/sdp_predict.sv
`timescale 1ns/1ps
module sdp_predict #(
  parameter int unsigned BINS  = sdp_pkg::DEF_WAYS + 1,
  parameter int unsigned CNT_W = sdp_pkg::DEF_CNT_W,
  localparam int unsigned BIN_W = $clog2(BINS),
  localparam int unsigned SUM_W = CNT_W + BIN_W
) (
  input  logic [CNT_W-1:0] row [BINS],
  input  logic [BIN_W-1:0] k,
  output logic [SUM_W-1:0] pred
);
  // misses plus every hit deeper than K
  always_comb begin
    pred = SUM_W'(row[BINS-1]);
    for (int b = 0; b < BINS - 1; b++)
      if (BIN_W'(b) >= k) pred = pred + SUM_W'(row[b]);
  end
endmodule

// File: rtl/sdp_profiler.sv
`timescale 1ns/1ps
module sdp_profiler #(
  parameter int unsigned WAYS    = sdp_pkg::DEF_WAYS,
  parameter int unsigned SETS    = sdp_pkg::DEF_SETS,
  parameter int unsigned TAG_W   = sdp_pkg::DEF_TAG_W,
  parameter int unsigned THREADS = sdp_pkg::DEF_THREADS,
  parameter int unsigned CNT_W   = sdp_pkg::DEF_CNT_W,
  parameter int unsigned CYC_W   = sdp_pkg::DEF_CYC_W,
  localparam int unsigned BINS  = WAYS + 1,
  localparam int unsigned POS_W = $clog2(BINS),
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned TID_W = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned SUM_W = CNT_W + POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             acc_valid,
  input  logic [TID_W-1:0] acc_tid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic [TID_W-1:0] rd_tid,
  input  logic [POS_W-1:0] rd_bin,
  input  logic [POS_W-1:0] rd_k,
  output logic [CNT_W-1:0] rd_bin_count,
  output logic [SUM_W-1:0] rd_pred_miss,
  output logic [CYC_W-1:0] cycle_count
);
  logic [WAYS-1:0]  hit_vec;
  logic [POS_W-1:0] hit_pos;
  logic             s1_valid;
  logic [TID_W-1:0] s1_tid;
  logic [POS_W-1:0] s1_pos;
  logic [CNT_W-1:0] row [BINS];
  logic [SUM_W-1:0] pred;

  sdp_recency #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_rec (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_tag(acc_tag), .hit_vec(hit_vec), .hit_pos(hit_pos)
  );

  // one register stage between the lookup and the counter bank
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_tid   <= '0;
      s1_pos   <= '0;
    end else begin
      s1_valid <= acc_valid && !clr;
      s1_tid   <= acc_tid;
      s1_pos   <= hit_pos;
    end
  end

  sdp_hist #(.THREADS(THREADS), .BINS(BINS), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst(rst), .clr(clr), .inc_valid(s1_valid), .inc_tid(s1_tid),
    .inc_bin(s1_pos), .rd_tid(rd_tid), .row(row)
  );

  sdp_predict #(.BINS(BINS), .CNT_W(CNT_W)) u_pred (
    .row(row), .k(rd_k), .pred(pred)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin_count <= '0;
      rd_pred_miss <= '0;
    end else begin
      rd_bin_count <= (rd_bin <= POS_W'(WAYS)) ? row[rd_bin] : '0;
      rd_pred_miss <= pred;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)            cycle_count <= '0;
    else if (cycle_count != '1) cycle_count <= cycle_count + 1'b1;
  end
endmodule

// File: rtl/sdp_profiler_chk.sv
`timescale 1ns/1ps
module sdp_profiler_chk #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned POS_W = 4,
  parameter int unsigned SET_W = 4,
  parameter int unsigned TAG_W = 12,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SUM_W = 36,
  parameter int unsigned CYC_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic [TAG_W-1:0] acc_tag,
  input logic [WAYS-1:0]  hit_vec,
  input logic             s1_valid,
  input logic [POS_W-1:0] s1_pos,
  input logic [POS_W-1:0] rd_bin,
  input logic [POS_W-1:0] rd_k,
  input logic [CNT_W-1:0] rd_bin_count,
  input logic [SUM_W-1:0] rd_pred_miss,
  input logic [CYC_W-1:0] cycle_count
);
  assert_unique_depth_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot0(hit_vec));

  assert_repeat_is_mru_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid ##1 (acc_valid && acc_set == $past(acc_set) && acc_tag == $past(acc_tag))
    |-> hit_vec[0]);

  assert_bin_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> s1_pos <= POS_W'(WAYS));

  assert_full_assoc_pred_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_k == POS_W'(WAYS) && rd_bin == POS_W'(WAYS)) |=> rd_pred_miss == SUM_W'(rd_bin_count));

  assert_clear_cycles_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> cycle_count == '0);

  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && cycle_count != '1) |=> cycle_count == $past(cycle_count) + 1'b1);
endmodule

bind sdp_profiler sdp_profiler_chk #(
  .WAYS(WAYS), .POS_W(POS_W), .SET_W(SET_W), .TAG_W(TAG_W),
  .CNT_W(CNT_W), .SUM_W(SUM_W), .CYC_W(CYC_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .acc_valid(acc_valid), .acc_set(acc_set),
  .acc_tag(acc_tag), .hit_vec(hit_vec), .s1_valid(s1_valid), .s1_pos(s1_pos),
  .rd_bin(rd_bin), .rd_k(rd_k), .rd_bin_count(rd_bin_count),
  .rd_pred_miss(rd_pred_miss), .cycle_count(cycle_count)
);

// File: tb/sdp_profiler_bench.sv
`timescale 1ns/1ps
module sdp_profiler_bench;
  localparam int WAYS = 8, SETS = 16, TAG_W = 12, THREADS = 2;
  localparam int CNT_W = 4, CYC_W = 40, POS_W = 4, SUM_W = CNT_W + POS_W;
  localparam int CMAX = 15;

  logic clk = 0, rst = 1, clr = 0, acc_valid = 0;
  logic [0:0] acc_tid = 0, rd_tid = 0;
  logic [3:0] acc_set = 0;
  logic [TAG_W-1:0] acc_tag = 0;
  logic [POS_W-1:0] rd_bin = 0, rd_k = 0;
  logic [CNT_W-1:0] rd_bin_count;
  logic [SUM_W-1:0] rd_pred_miss;
  logic [CYC_W-1:0] cycle_count;

  always #10 clk = ~clk;

  sdp_profiler #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .THREADS(THREADS),
                 .CNT_W(CNT_W), .CYC_W(CYC_W)) u_sdp_profiler (
    .clk(clk), .rst(rst), .clr(clr), .acc_valid(acc_valid), .acc_tid(acc_tid),
    .acc_set(acc_set), .acc_tag(acc_tag), .rd_tid(rd_tid), .rd_bin(rd_bin),
    .rd_k(rd_k), .rd_bin_count(rd_bin_count), .rd_pred_miss(rd_pred_miss),
    .cycle_count(cycle_count)
  );

  int total = 0, bad = 0, cyc_n = 0;

  typedef struct { int due; int exp_cnt; int exp_pred; string req; } item_t;
  item_t q[$];

  // reference recency model built from the requirements
  int mt[SETS][WAYS];
  bit mv[SETS][WAYS];
  int eh[THREADS][WAYS+1];

  task automatic model_clear();
    for (int t = 0; t < THREADS; t++)
      for (int b = 0; b <= WAYS; b++) eh[t][b] = 0;
  endtask

  task automatic access(input int t, input int s, input int tag);
    int p;
    @(negedge clk);
    acc_valid = 1; acc_tid = t[0:0]; acc_set = s[3:0]; acc_tag = tag[TAG_W-1:0];
    p = WAYS;
    for (int j = WAYS - 1; j >= 0; j--) if (mv[s][j] && mt[s][j] == tag) p = j;
    if (eh[t][p] < CMAX) eh[t][p]++;
    for (int j = WAYS - 1; j >= 1; j--)
      if (j <= p) begin mt[s][j] = mt[s][j-1]; mv[s][j] = mv[s][j-1]; end
    mt[s][0] = tag; mv[s][0] = 1;
  endtask

  task automatic read(input int t, input int b, input int k, input string req);
    item_t it;
    int ep;
    @(negedge clk);
    acc_valid = 0;
    @(negedge clk);
    rd_tid = t[0:0]; rd_bin = b[POS_W-1:0]; rd_k = k[POS_W-1:0];
    ep = eh[t][WAYS];
    for (int j = k; j < WAYS; j++) ep += eh[t][j];
    it.due = cyc_n + 1; it.exp_cnt = eh[t][b]; it.exp_pred = ep; it.req = req;
    q.push_back(it);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #5;
      cyc_n++;
      if (q.size() > 0 && q[0].due <= cyc_n) begin
        item_t it;
        it = q.pop_front();
        chk(rd_bin_count == CNT_W'(it.exp_cnt), {it.req, " bin"}, rd_bin_count, it.exp_cnt);
        chk(rd_pred_miss == SUM_W'(it.exp_pred), {it.req, " pred"}, rd_pred_miss, it.exp_pred);
      end
    end
  end

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint c1;
    for (int s = 0; s < SETS; s++) for (int j = 0; j < WAYS; j++) mv[s][j] = 0;
    model_clear();
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: all bins zero after reset
    for (int b = 0; b <= WAYS; b++) read(0, b, 0, "R10 reset t0");
    read(1, 8, 0, "R10 reset t1");
    // R3 cold misses, R2 hits at depths 3 and 1, R11 timing
    access(0, 1, 10); access(0, 1, 11); access(0, 1, 12);
    access(0, 1, 10);
    read(0, 8, 8, "R3 misses");
    read(0, 2, 8, "R2 depth3 R11");
    access(0, 1, 10); access(0, 1, 11);
    read(0, 0, 8, "R4 repeat at depth1");
    read(0, 2, 8, "R4 shifted depth3");
    // R5: other thread shares ordering, other set isolated
    access(1, 1, 12); access(1, 2, 10);
    read(1, 2, 8, "R5 shared set depth");
    read(1, 8, 8, "R5 other set miss");
    read(0, 8, 8, "R2 other thread untouched");
    // R4: eviction from a full set
    for (int i = 0; i < 9; i++) access(0, 3, 100 + i);
    access(0, 3, 100);
    access(0, 3, 101);
    read(0, 8, 8, "R4 evicted miss");
    read(0, 7, 8, "R4 deepest hit");
    // R6 and R1: sweep K
    for (int k = 0; k <= WAYS; k++) read(0, k, k, "R6 R1 sweep");
    // R7 saturation
    for (int i = 0; i < 20; i++) access(1, 5, 7);
    read(1, 0, 0, "R7 saturate");
    // R8 clear
    @(negedge clk); acc_valid = 0; clr = 1;
    @(negedge clk); clr = 0; model_clear();
    chk(cycle_count <= 1, "R8 cycles cleared", cycle_count, 0);
    read(0, 8, 0, "R8 bins cleared");
    read(1, 0, 0, "R8 bins cleared t1");
    access(0, 1, 11);
    read(0, 0, 8, "R8 ordering kept");
    // R9 cycle counter step
    @(negedge clk); c1 = cycle_count;
    repeat (10) @(negedge clk);
    chk(cycle_count - c1 == 10, "R9 cycle step", cycle_count - c1, 10);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule